// File: doc/BRIEF.md
# Sequential Triangular-Sum Accumulator

The block computes the triangular number 0+1+2+...+N for an unsigned target N. It uses one adder and no multiplier. A start strobe latches the target and clears a term counter and an accumulator. After that, the block adds the current term into the running sum once per clock and steps the term by one. The run continues until an equality check finds that the term matches the latched target.

When the last term has been added, the block drops its busy flag, raises a done pulse for a single cycle and holds the sum until the next accepted start. A host starts a job, waits for the done pulse, then reads the sum. The running sum can also be read on the sum port while the job is in progress.

Top module: `trisum_engine`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears sum_o, busy_o and done_o to 0 at that edge.
- R2: A start_i sampled high while busy_o is low is accepted. It latches target_i, and from the next cycle busy_o is 1 and sum_o is 0.
- R3: When the run completes, sum_o equals N*(N+1)/2 for the latched target N. With the default 8-bit target, sum_o is 16 bits wide, so the largest result (N=255, 32640) fits without overflow.
- R4: For a target N, busy_o stays high for exactly N+1 consecutive cycles after the accepting edge.
- R5: done_o is high for exactly one cycle. That cycle is the first one in which busy_o is low after a run.
- R6: A target of 0 completes after one busy cycle with sum_o equal to 0, and still produces the done pulse.
- R7: A start_i pulse while busy_o is high is ignored. So is any change on target_i during a run. The result and the run length stay those of the accepted target.
- R8: While busy_o is low and no start is accepted, sum_o holds its value.
- R9: In the c-th busy cycle (c counted from 1), sum_o shows 0+1+...+(c-2), and 0 when c is 1. The running sum never decreases during a run.
- R10: The run stops only when every bit of the term equals the matching target bit. This includes the all-ones target 255 and the single-high-bit target 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| target_i | input | 8 | Last term N of the sum, sampled on an accepted start |
| sum_o | output | 16 | Running sum, and the final result after done |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The bench runs the target values 0, 1, 5, 128 and 255, and checks the running sum in every busy cycle as well as the final result.

- A counter with a faulty carry chain would skip or repeat terms, so the per-cycle sums would go wrong.
- An equality check that misses a bit would stop early or run past the target, which changes both the run length and the result.
- A design that accepts a start while busy would restart and report the wrong sum.
- A reset in the middle of a run must leave all three outputs at zero with no stray done pulse.
- A target of 0 must still finish with a done pulse.

// File: rtl/trisum_pkg.sv
// Shared types for the triangular-sum engine.
// Assumes nothing beyond the parameters chosen at the top.
package trisum_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } trisum_state_e;

    // Width needed to hold 0+1+...+(2**w - 1) without overflow.
    function automatic int sum_width(input int w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/trisum_term_counter.sv
// Term counter: an incrementer built as a toggle chain.
// Bit k flips when every lower bit is one.
// Assumes clear and advance are never high in the same cycle.
module trisum_term_counter #(
    parameter int TERM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [TERM_W-1:0] term
);

    logic [TERM_W:0]   carry;
    logic [TERM_W-1:0] term_nxt;

    assign carry[0] = 1'b1;

    // Per-bit toggle: the carry is the AND of all lower bits.
    for (genvar k = 0; k < TERM_W; k++) begin : g_bit
        assign carry[k+1]  = carry[k] & term[k];
        assign term_nxt[k] = term[k] ^ carry[k];
    end

    // Term register: reset or clear to zero, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            term <= '0;
        end else if (advance) begin
            term <= term_nxt;
        end
    end

endmodule

// File: rtl/trisum_match.sv
// Equality detector.
// XORs each bit pair, and reports a match when no XOR output is one.
// Purely combinational.
module trisum_match #(
    parameter int TERM_W = 8
) (
    input  logic [TERM_W-1:0] count,
    input  logic [TERM_W-1:0] limit,
    output logic              equal
);

    logic [TERM_W-1:0] diff;

    // Per-bit difference.
    for (genvar k = 0; k < TERM_W; k++) begin : g_xor
        assign diff[k] = count[k] ^ limit[k];
    end

    assign equal = ~|diff;

endmodule

// File: rtl/trisum_accum.sv
// Accumulator: adds the zero-extended term once per enabled cycle.
// Assumes SUM_W is at least TERM_W.
module trisum_accum #(
    parameter int TERM_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [TERM_W-1:0] term,
    output logic [SUM_W-1:0]  sum
);

    localparam int PAD_W = SUM_W - TERM_W;

    logic [SUM_W-1:0] term_ext;

    assign term_ext = {{PAD_W{1'b0}}, term};

    // Running-sum register: reset or clear to zero, otherwise add the term.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + term_ext;
        end
    end

endmodule

// File: rtl/trisum_engine.sv
// Triangular-sum engine top level.
// An accepted start latches the target. Each run cycle adds the term,
// then either steps the term or, on a match, finishes with a done pulse.
// Assumes start is a level sampled at the rising edge. It is ignored while busy.
module trisum_engine
    import trisum_pkg::*;
#(
    parameter int TERM_W = 8,
    parameter int SUM_W  = sum_width(TERM_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TERM_W-1:0] target_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic              busy_o,
    output logic              done_o
);

    trisum_state_e     state_q;
    logic [TERM_W-1:0] tgt_q;
    logic [TERM_W-1:0] term;
    logic              hit;
    logic              accept;
    logic              running;
    logic              finish;

    assign running = (state_q == ST_RUN);
    assign accept  = start_i && !running;
    assign finish  = running && hit;

    // Control: idle/run state, latched target and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= finish;
            if (accept) begin
                state_q <= ST_RUN;
                tgt_q   <= target_i;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end
        end
    end

    trisum_term_counter #(.TERM_W(TERM_W)) u_term (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (running && !hit),
        .term    (term)
    );

    trisum_match #(.TERM_W(TERM_W)) u_match (
        .count (term),
        .limit (tgt_q),
        .equal (hit)
    );

    trisum_accum #(.TERM_W(TERM_W), .SUM_W(SUM_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .add_en (running),
        .term   (term),
        .sum    (sum_o)
    );

    assign busy_o = running;

endmodule

// File: rtl/trisum_engine_checker.sv
// Checker for the triangular-sum engine, bound to every instance.
module trisum_engine_checker #(
    parameter int TERM_W = 8,
    parameter int SUM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [SUM_W-1:0]  sum_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [TERM_W-1:0] tgt_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && !busy_o && !done_o));

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && sum_o == '0));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy_o && $past(busy_o)));

    p_target_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && $past(busy_o)) |-> $stable(tgt_q));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sum_o));

    p_sum_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (sum_o >= $past(sum_o)));

endmodule

bind trisum_engine trisum_engine_checker #(
    .TERM_W (TERM_W),
    .SUM_W  (SUM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .sum_o   (sum_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .tgt_q   (tgt_q)
);

// File: tb/trisum_engine_test.sv
// Scoreboard bench for the triangular-sum engine.
module trisum_engine_test;

    localparam int TW = 8;
    localparam int SW = 16;

    typedef struct {
        int sum;
        int cycles;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [TW-1:0] target_i = '0;
    logic [SW-1:0] sum_o;
    logic          busy_o;
    logic          done_o;

    int   checks = 0;
    int   errors = 0;
    int   busy_cnt = 0;
    int   done_seen = 0;
    int   cyc = 0;
    exp_t expq[$];

    always #10 clk = ~clk;  // 50 MHz

    trisum_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .target_i (target_i),
        .sum_o    (sum_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    function automatic int tri_of(input int n);
        return (n < 0) ? 0 : n * (n + 1) / 2;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compares the running sum in every cycle and pops at done.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            busy_cnt = 0;
        end else begin
            if (busy_o) begin
                busy_cnt++;
                // R9: running sum in busy cycle c is tri(c-2).
                check("R9 running sum", int'(sum_o), tri_of(busy_cnt - 2));
            end
            if (done_o) begin
                check("R5 busy low at done", int'(busy_o), 0);
                if (expq.size() == 0) begin
                    check("R5 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R3 final sum", int'(sum_o), e.sum);
                    check("R4 busy length", busy_cnt, e.cycles);
                end
                busy_cnt = 0;
                done_seen++;
            end
        end
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Driver: issues one job and pushes its expected result.
    task automatic issue(input int n);
        exp_t e;
        e.sum    = tri_of(n);
        e.cycles = n + 1;
        expq.push_back(e);
        @(negedge clk);
        start_i  = 1'b1;
        target_i = TW'(n);
        @(negedge clk);
        start_i  = 1'b0;
        // R2: busy set and sum cleared one cycle after the accepting edge.
        check("R2 busy after start", int'(busy_o), 1);
        check("R2 sum cleared", int'(sum_o), 0);
    endtask

    task automatic wait_done();
        int d;
        d = done_seen;
        while (done_seen == d) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 sum", int'(sum_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        rst_n = 1'b1;

        // R3 with target 5, and R8 hold after done.
        issue(5);
        wait_done();
        repeat (4) @(negedge clk);
        check("R8 sum held", int'(sum_o), 15);
        check("R5 done dropped", int'(done_o), 0);

        // R6: target 0.
        issue(0);
        wait_done();
        check("R6 zero sum", int'(sum_o), 0);

        issue(1);
        wait_done();

        // R10: single-high-bit and all-ones targets.
        issue(128);
        wait_done();
        check("R10 target 128", int'(sum_o), 8256);
        issue(255);
        wait_done();
        check("R3 R10 max 32640", int'(sum_o), 32640);

        // R7: start and a new target while busy are ignored.
        issue(20);
        repeat (5) @(negedge clk);
        start_i  = 1'b1;
        target_i = 8'd3;
        @(negedge clk);
        start_i  = 1'b0;
        target_i = 8'd200;
        wait_done();
        check("R7 result kept", int'(sum_o), 210);

        // R1: reset in the middle of a run.
        issue(50);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        expq.delete();
        @(negedge clk);
        @(negedge clk);
        check("R1 mid-run sum", int'(sum_o), 0);
        check("R1 mid-run busy", int'(busy_o), 0);
        check("R1 mid-run done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 idle after reset", int'(sum_o), 0);

        // R2: start in the cycle right after done is accepted.
        issue(2);
        wait_done();
        issue(3);
        wait_done();
        check("R3 back-to-back", int'(sum_o), 6);

        check("R5 queue drained", expq.size(), 0);
        finish_run();
    end

endmodule